// File: doc/BRIEF.md
# Playback DMA Byte Counter with Interrupt

This block sits between the register file of an audio playback path and the bus-side DMA engine. While playback is switched on, it holds a DMA request high and takes one byte per acknowledge pulse. It counts those bytes against a terminal value. The terminal value is a 16-bit base count, assembled from an upper and a lower register byte, multiplied by the frame size of the current sample format. The frame size is given as a left shift.

When the count reaches the terminal value, the block raises a level interrupt and sets two flags: a status INT bit and a playback-interrupt flag. The count then restarts from zero, so the next interrupt arrives after one more full buffer. The register block clears the interrupt through one of two paths: a write to the status address, or a write to the alternate status register that drops the playback flag.

Each DMA acknowledge counts as one byte. This holds in companded formats too, where one input byte becomes two output bytes. When the interrupt-enable bit is off, the stream runs without end and no interrupt is raised.

Top module: `pb_dma_irq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `dma_req`, `irq`, `stat_int` and `flag_pi` are all 0.
- R2: The terminal byte count is `{base_hi, base_lo} << frame_shift`, where `frame_shift` ranges from 0 to 3. The interrupt fires on the accepted acknowledge that brings the byte count to the terminal value, and not on any acknowledge before it.
- R3: One cycle after `play_en` is 1 and `pio_mode` is 0, `dma_req` is 1 (R10 gives the one exception). While playback is off, `dma_req` is 0 one cycle later and the byte counter is held at zero, so a restart counts a full terminal value again.
- R4: After an interrupt, the byte counter restarts at zero, and the next interrupt comes after exactly one more terminal count of accepted acknowledges.
- R5: A terminal event sets `stat_int`, `flag_pi` and `irq` together. They are visible in the cycle after the clock edge that accepted the last byte.
- R6: While `pio_mode` is 1, the request is withheld. An acknowledge that arrives while `dma_req` is 0 is ignored, and the count does not advance.
- R7: A pulse on `clr_status` clears `stat_int`, `irq` and `flag_pi`. A pulse on `flag_wr` loads `flag_wr_pi` into `flag_pi`. Writing 0 while `flag_pi` is 1 also clears `stat_int` and `irq`. Writing 1 does not touch `stat_int`.
- R8: While `irq_en` is 0, accepted bytes raise no interrupt, the counter does not advance, and `dma_req` stays high for as long as playback runs.
- R9: `irq` is a level. It stays high until one of the R7 clears. If a terminal event and a clear happen in the same cycle, the terminal event wins.
- R10: If `irq_en` is 1 and the terminal count is zero, `dma_req` is 0 even while playback runs.
- R11: If the base count or the shift is lowered below the current byte count, the next accepted acknowledge fires the interrupt and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| play_en | input | 1 | Playback enable bit |
| pio_mode | input | 1 | Programmed-I/O mode bit; blocks DMA when set |
| irq_en | input | 1 | Interrupt enable bit |
| base_hi | input | 8 | Upper byte of base count |
| base_lo | input | 8 | Lower byte of base count |
| frame_shift | input | 2 | Log2 of bytes per frame |
| dma_ack | input | 1 | One-byte DMA acknowledge |
| clr_status | input | 1 | Strobe: write to status address |
| flag_wr | input | 1 | Strobe: write to alternate status register |
| flag_wr_pi | input | 1 | Playback flag value carried by that write |
| dma_req | output | 1 | DMA request (registered) |
| irq | output | 1 | Level interrupt line |
| stat_int | output | 1 | Status INT bit |
| flag_pi | output | 1 | Playback interrupt flag |

## Verification
All four outputs come from registers, so each result is due exactly one clock after the edge that samples its cause. This applies to a request change after an enable change, to an interrupt after the last acknowledge, and to a flag change after a clear strobe. The bench drives inputs on the falling edge and compares outputs on the next falling edge, one full edge after the rising edge that updates both the design and the bench's model. Directed sequences check literal values at the terminal byte and at the byte just before it. Random runs compare every cycle against a model built from the requirements.

// File: rtl/pb_dma_pkg.sv
package pb_dma_pkg;
  // Flag events presented to the interrupt flag register in one cycle.
  typedef struct packed {
    logic hit;      // terminal count reached
    logic clr_all;  // status-address write
    logic wr;       // alternate status write
    logic wr_pi;    // value of playback flag in that write
  } flag_evt_t;

  function automatic int cnt_width(input int byte_w, input int shift_w);
    return 2 * byte_w + (2 ** shift_w) - 1;
  endfunction
endpackage

// File: rtl/pb_req_ctrl.sv
module pb_req_ctrl #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             play_en,
  input  logic             pio_mode,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] term,
  output logic             run,
  output logic             dma_req
);
  logic zero_lim;

  assign run      = play_en && !pio_mode;
  assign zero_lim = irq_en && (term == '0);

  always_ff @(posedge clk) begin
    if (rst) dma_req <= 1'b0;
    else     dma_req <= run && !zero_lim;
  end
endmodule

// File: rtl/pb_byte_cnt.sv
module pb_byte_cnt #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             irq_en,
  input  logic             take,
  input  logic [CNT_W-1:0] term,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   nxt;
  logic             adv;

  assign nxt = {1'b0, cnt_q} + 1'b1;
  assign adv = run && irq_en && take;
  assign hit = adv && (nxt >= {1'b0, term});

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (hit)     cnt_q <= '0;
    else if (adv)     cnt_q <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/pb_irq_flags.sv
module pb_irq_flags
  import pb_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_evt_t evt,
  output logic      stat_int,
  output logic      flag_pi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_int <= 1'b0;
      flag_pi  <= 1'b0;
    end else if (evt.hit) begin
      stat_int <= 1'b1;
      flag_pi  <= 1'b1;
    end else if (evt.clr_all) begin
      stat_int <= 1'b0;
      flag_pi  <= 1'b0;
    end else if (evt.wr) begin
      if (flag_pi && !evt.wr_pi) stat_int <= 1'b0;
      flag_pi <= evt.wr_pi;
    end
  end
endmodule

// File: rtl/pb_dma_irq.sv
module pb_dma_irq
  import pb_dma_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int SHIFT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               play_en,
  input  logic               pio_mode,
  input  logic               irq_en,
  input  logic [BYTE_W-1:0]  base_hi,
  input  logic [BYTE_W-1:0]  base_lo,
  input  logic [SHIFT_W-1:0] frame_shift,
  input  logic               dma_ack,
  input  logic               clr_status,
  input  logic               flag_wr,
  input  logic               flag_wr_pi,
  output logic               dma_req,
  output logic               irq,
  output logic               stat_int,
  output logic               flag_pi
);
  localparam int CNT_W = cnt_width(BYTE_W, SHIFT_W);

  logic [CNT_W-1:0] term;
  logic             run;
  logic             hit;
  flag_evt_t        evt;

  assign term = CNT_W'({base_hi, base_lo}) << frame_shift;

  pb_req_ctrl #(.CNT_W(CNT_W)) u_req (
    .clk(clk), .rst(rst), .play_en(play_en), .pio_mode(pio_mode),
    .irq_en(irq_en), .term(term), .run(run), .dma_req(dma_req)
  );

  pb_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .irq_en(irq_en),
    .take(dma_ack && dma_req), .term(term), .hit(hit)
  );

  assign evt = '{hit: hit, clr_all: clr_status, wr: flag_wr, wr_pi: flag_wr_pi};

  pb_irq_flags u_flags (
    .clk(clk), .rst(rst), .evt(evt), .stat_int(stat_int), .flag_pi(flag_pi)
  );

  assign irq = stat_int;
endmodule

// File: rtl/pb_dma_irq_chk.sv
module pb_dma_irq_chk (
  input logic clk,
  input logic rst,
  input logic play_en,
  input logic pio_mode,
  input logic irq_en,
  input logic dma_ack,
  input logic clr_status,
  input logic flag_wr,
  input logic flag_wr_pi,
  input logic dma_req,
  input logic irq,
  input logic stat_int,
  input logic flag_pi
);
  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    !(play_en && !pio_mode) |=> !dma_req); // R3

  AST_RISE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(dma_ack && dma_req && irq_en)); // R5

  AST_FLAGS_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_int) |-> flag_pi); // R5

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_status && !dma_ack) |=> (!stat_int && !flag_pi)); // R7

  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!irq_en && !irq) |=> !irq); // R8

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_status && !(flag_wr && !flag_wr_pi)) |=> irq); // R9

  AST_PIO_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    pio_mode |=> !dma_req); // R6
endmodule

bind pb_dma_irq pb_dma_irq_chk u_chk (
  .clk(clk), .rst(rst), .play_en(play_en), .pio_mode(pio_mode),
  .irq_en(irq_en), .dma_ack(dma_ack), .clr_status(clr_status),
  .flag_wr(flag_wr), .flag_wr_pi(flag_wr_pi), .dma_req(dma_req),
  .irq(irq), .stat_int(stat_int), .flag_pi(flag_pi)
);

// File: tb/pb_dma_irq_tb.sv
module pb_dma_irq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic play_en = 0, pio_mode = 0, irq_en = 0;
  logic [7:0] base_hi = 0, base_lo = 0;
  logic [1:0] frame_shift = 0;
  logic dma_ack = 0, clr_status = 0, flag_wr = 0, flag_wr_pi = 0;
  logic dma_req, irq, stat_int, flag_pi;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  logic        m_req, m_int, m_pi;
  logic [19:0] m_cnt;

  always #2 clk = ~clk;  // 250 MHz

  pb_dma_irq u_dut (
    .clk(clk), .rst(rst), .play_en(play_en), .pio_mode(pio_mode),
    .irq_en(irq_en), .base_hi(base_hi), .base_lo(base_lo),
    .frame_shift(frame_shift), .dma_ack(dma_ack), .clr_status(clr_status),
    .flag_wr(flag_wr), .flag_wr_pi(flag_wr_pi), .dma_req(dma_req),
    .irq(irq), .stat_int(stat_int), .flag_pi(flag_pi)
  );

  function automatic logic [19:0] term_of(logic [7:0] h, logic [7:0] l, logic [1:0] s);
    return {4'd0, h, l} << s;
  endfunction

  always @(posedge clk) begin
    logic run, hit;
    logic [19:0] t;
    if (rst) begin
      m_req = 0; m_int = 0; m_pi = 0; m_cnt = 0;
    end else begin
      run = play_en && !pio_mode;
      t   = term_of(base_hi, base_lo, frame_shift);
      hit = 0;
      if (!run) m_cnt = 0;
      else if (dma_ack && m_req && irq_en) begin
        if (m_cnt + 1 >= t) begin m_cnt = 0; hit = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (hit) begin m_int = 1; m_pi = 1; end
      else if (clr_status) begin m_int = 0; m_pi = 0; end
      else if (flag_wr) begin
        if (m_pi && !flag_wr_pi) m_int = 0;
        m_pi = flag_wr_pi;
      end
      m_req = run && !(irq_en && t == 0);
    end
  end

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s req/irq/int/pi got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] outs();
    return {dma_req, irq, stat_int, flag_pi};
  endfunction

  task automatic cmp(string tag);
    chk(tag, outs(), {m_req, m_int, m_int, m_pi});
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic acks(int n, string tag);
    for (int i = 0; i < n; i++) begin
      dma_ack = 1; cyc(); cmp(tag);
    end
    dma_ack = 0;
  endtask

  task automatic pulse_clr();
    clr_status = 1; cyc(); clr_status = 0;
  endtask

  task automatic pulse_wr(logic v);
    flag_wr = 1; flag_wr_pi = v; cyc(); flag_wr = 0; flag_wr_pi = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    cyc(); chk("R1 in reset", outs(), 4'b0000);
    rst = 0; cyc(); chk("R1 after release", outs(), 4'b0000);

    // R2/R3/R5: term = 3 << 1 = 6
    irq_en = 1; base_lo = 8'd3; frame_shift = 2'd1; play_en = 1;
    cyc(); chk("R3 request up", outs(), 4'b1000);
    acks(5, "R2 before term");
    chk("R2 no irq at byte 5", outs(), 4'b1000);
    acks(1, "R5 terminal");
    chk("R5 irq at byte 6", outs(), 4'b1111);
    repeat (3) cyc();
    chk("R9 level held", outs(), 4'b1111);
    pulse_wr(1'b1); chk("R7 write pi=1 keeps int", outs(), 4'b1111);
    pulse_wr(1'b0); chk("R7 write pi=0 clears", outs(), 4'b1000);

    // R4: next interrupt after another full 6
    acks(5, "R4 reload"); chk("R4 no irq at 5", outs(), 4'b1000);
    acks(1, "R4 reload"); chk("R4 irq at 6", outs(), 4'b1111);
    pulse_clr(); chk("R7 status clear", outs(), 4'b1000);

    // R2 upper byte: term 256
    base_hi = 8'd1; base_lo = 8'd0; frame_shift = 0;
    acks(255, "R2 upper"); chk("R2 no irq at 255", outs(), 4'b1000);
    acks(1, "R2 upper"); chk("R2 irq at 256", outs(), 4'b1111);
    pulse_clr();

    // R9: terminal and clear in same cycle -> set wins
    base_hi = 0; base_lo = 8'd2; frame_shift = 0;
    acks(1, "R9 prep");
    dma_ack = 1; clr_status = 1; cyc(); dma_ack = 0; clr_status = 0;
    chk("R9 set beats clear", outs(), 4'b1111);
    pulse_clr();

    // R11: lower term below current count
    base_lo = 8'd10; acks(5, "R11 prep");
    base_lo = 8'd2; acks(1, "R11 fire");
    chk("R11 fires after lowering", outs(), 4'b1111);
    pulse_clr();

    // R8: interrupts disabled
    irq_en = 0; base_lo = 8'd1;
    acks(300, "R8 no irq"); chk("R8 req continuous", outs(), 4'b1000);

    // R6: pio mode blocks request and acks
    irq_en = 1; base_lo = 8'd1; pio_mode = 1; cyc();
    chk("R6 pio blocks req", outs(), 4'b0000);
    acks(3, "R6 ack ignored"); chk("R6 no irq", outs(), 4'b0000);
    pio_mode = 0; cyc();

    // R3: disable clears counter; term 4
    base_lo = 8'd4; acks(2, "R3 prep");
    play_en = 0; cyc(); chk("R3 req drop", outs(), 4'b0000);
    play_en = 1; cyc();
    acks(3, "R3 restart"); chk("R3 no irq at 3 after restart", outs(), 4'b1000);
    acks(1, "R3 restart"); chk("R3 irq at 4", outs(), 4'b1111);
    pulse_clr();

    // R10: zero terminal withholds request
    base_lo = 0; cyc(); chk("R10 zero term", outs(), 4'b0000);
    irq_en = 0; cyc(); chk("R10 no limit when irq off", outs(), 4'b1000);

    // random phase
    for (int blk = 0; blk < 40; blk++) begin
      base_hi = ($urandom % 8 == 0) ? 8'd1 : 8'd0;
      base_lo = 8'($urandom % 8);
      frame_shift = 2'($urandom % 4);
      irq_en = ($urandom % 5) != 0;
      play_en = ($urandom % 6) != 0;
      pio_mode = ($urandom % 10) == 0;
      for (int i = 0; i < 150; i++) begin
        dma_ack = ($urandom % 10) < 7;
        clr_status = ($urandom % 30) == 0;
        flag_wr = ($urandom % 30) == 0;
        flag_wr_pi = $urandom % 2;
        cyc();
        cmp("R2 R4 R7 random");
      end
    end
    dma_ack = 0; clr_status = 0; flag_wr = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule